// File: doc/BRIEF.md
# Trace Frame Packer

This block sits between a per-cycle trace port and a 32-bit trace store. On every clock cycle it may accept one trace sample. A sample is made of a 3-bit pipeline status, a packet field and a sync flag. The block gathers samples into storage words. How many samples fit in a word depends on the selected port width: three samples in 4-bit mode, two in 8-bit mode and one in 16-bit mode. When a word is full, the block presents it for one cycle with a valid strobe.

A sample taken on a trigger cycle is marked inside its own slot. Its status field carries a reserved code, and the real status moves into the low bits of its packet field. Capture is enabled by a level input. When capture is dropped while a word is only partly filled, the block emits that word with its empty slots zeroed. A drained output tells the consumer that nothing is left inside the block.

Top module: `trace_frame_packer`

## Requirements
- R1: While reset is asserted and after it is released, `word_valid` is 0 and `drained` is 1 until the first sample is accepted or capture is enabled.
- R2: A sample's slot is `{sync, packet, status}`, with status in bits [2:0] and packet in the bits just above it. The packet uses the low 4, 8 or 16 bits of `smp_pkt` for the 4-, 8- and 16-bit modes, which gives 8-, 12- and 20-bit slots. Sync is the top bit of the slot.
- R3: `port_mode` selects the layout. 0 is 4-bit mode, with three slots at [7:0], [15:8] and [23:16]. 1 is 8-bit mode, with two slots at [11:0] and [23:12]. 2 and 3 are 16-bit mode, with one slot at [19:0]. The earliest accepted sample of a word takes the lowest slot.
- R4: `word_valid` is a one-cycle pulse. It is high in the cycle after the clock edge at which the sample that fills the last slot is accepted.
- R5: When `smp_trig` is 1, the slot's status field holds the code 3'b110. Packet bits [2:0] hold the real `smp_stat`, and the packet bits above bit 2 keep their `smp_pkt` values.
- R6: Word bits above the last slot (bits [31:24] in 4-bit and 8-bit mode, bits [31:20] in 16-bit mode) are zero in every emitted word.
- R7: A sample is accepted only at an edge where both `cap_en` and `smp_valid` are 1. Other cycles take no slot and do not change later words.
- R8: At the first edge with `cap_en` low while a word is partly filled, the block emits that word. Its empty slots are zero.
- R9: After each edge, `drained` is 1 exactly when `cap_en` was low at that edge and no partly filled word remains. It rises in the same cycle as a flushed word's `word_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_mode | input | 2 | Port width select (0: 4-bit, 1: 8-bit, 2/3: 16-bit) |
| cap_en | input | 1 | Capture enable level |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_stat | input | 3 | Pipeline status of the sample |
| smp_pkt | input | 16 | Packet field of the sample (low bits used per mode) |
| smp_sync | input | 1 | Sync flag of the sample |
| smp_trig | input | 1 | The sample is a trigger cycle |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| word_data | output | 32 | Packed storage word |
| drained | output | 1 | Capture stopped and no partial word held |

## Verification
The assertions assume that `port_mode` holds still whenever a partly filled word exists. In other words, the width only changes while capture is off and the block is empty. The stimulus follows this rule. It changes the mode only after a flush has completed and `drained` has been seen high.

The assertions also assume that reset leaves the slot counter below the slot count of the current mode. The stimulus sweeps every mode, every partial fill level from one sample up, runs with gaps in `smp_valid`, and trigger cycles placed in varying slots. It also presents samples while capture is off, to show that they are not taken.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

  localparam int STAT_W    = 3;
  localparam int PKT_MAX_W = 16;
  localparam int SLOT_MAX_W = STAT_W + PKT_MAX_W + 1;

  typedef enum logic [1:0] {
    MODE_N4  = 2'd0,
    MODE_N8  = 2'd1,
    MODE_N16 = 2'd2,
    MODE_ALT = 2'd3
  } tfp_mode_e;

  // packet width carried per slot for a mode index
  function automatic int pkt_w_of(input int m);
    case (m)
      0:       return 4;
      1:       return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int slot_w_of(input logic [1:0] m);
    return pkt_w_of(int'(m)) + STAT_W + 1;
  endfunction

  function automatic logic [1:0] slots_of(input logic [1:0] m);
    case (tfp_mode_e'(m))
      MODE_N4: return 2'd3;
      MODE_N8: return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic int used_bits_of(input logic [1:0] m);
    return int'(slots_of(m)) * slot_w_of(m);
  endfunction

endpackage

// File: rtl/tfp_fmt.sv
module tfp_fmt
  import tfp_pkg::*;
#(
  parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
  input  logic [1:0]            mode,
  input  logic [STAT_W-1:0]     stat,
  input  logic [PKT_MAX_W-1:0]  pkt,
  input  logic                  sync,
  input  logic                  trig,
  output logic [SLOT_MAX_W-1:0] field
);

  localparam int NMODES = 3;

  logic [SLOT_MAX_W-1:0] cand [NMODES];

  // one slot builder per port width
  for (genvar g = 0; g < NMODES; g++) begin : g_mode
    localparam int PW = pkt_w_of(g);
    localparam int FW = PW + STAT_W + 1;
    logic [PW-1:0]     pkt_eff;
    logic [STAT_W-1:0] stat_eff;
    logic [FW-1:0]     raw;

    always_comb begin
      pkt_eff  = pkt[PW-1:0];
      stat_eff = stat;
      if (trig) begin
        pkt_eff[STAT_W-1:0] = stat;
        stat_eff            = TRIG_CODE;
      end
      raw = {sync, pkt_eff, stat_eff};
    end

    assign cand[g] = SLOT_MAX_W'(raw);
  end

  always_comb begin
    case (tfp_mode_e'(mode))
      MODE_N4: field = cand[0];
      MODE_N8: field = cand[1];
      default: field = cand[2];
    endcase
  end

endmodule

// File: rtl/tfp_slot_ctrl.sv
module tfp_slot_ctrl
  import tfp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       cap_en,
  input  logic       smp_valid,
  output logic       take,
  output logic [1:0] slot_idx,
  output logic       last,
  output logic       flush,
  output logic       drained
);

  logic [1:0] cnt_q, cnt_d;
  logic       cnt_en;
  logic       drained_q, drained_d;
  logic [1:0] nslot;

  assign nslot = slots_of(mode);

  always_comb begin
    take      = cap_en & smp_valid;
    last      = take && (cnt_q == nslot - 2'd1);
    flush     = !cap_en && (cnt_q != 2'd0);
    cnt_en    = take | flush;
    cnt_d     = cnt_q;
    if (last || flush)
      cnt_d = 2'd0;
    else if (take)
      cnt_d = cnt_q + 2'd1;
    drained_d = !cap_en && (cnt_d == 2'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= 2'd0;
      drained_q <= 1'b1;
    end else begin
      if (cnt_en)
        cnt_q <= cnt_d;
      drained_q <= drained_d;
    end
  end

  assign slot_idx = cnt_q;
  assign drained  = drained_q;

  // R3: fill level never reaches the slot count of the current width
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < nslot);

  // R3 input rule: width held while a word is partly filled
  p_mode_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != 2'd0) |-> $stable(mode));

  // R9: drained never claims while a partial word exists
  p_drained_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drained_q |-> (cnt_q == 2'd0));

endmodule

// File: rtl/tfp_word_asm.sv
module tfp_word_asm
  import tfp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode,
  input  logic                  take,
  input  logic [1:0]            slot_idx,
  input  logic                  last,
  input  logic                  flush,
  input  logic [SLOT_MAX_W-1:0] field,
  output logic                  word_valid,
  output logic [WORD_W-1:0]     word_data
);

  logic [WORD_W-1:0] acc_q, acc_d, word_q, word_d;
  logic              acc_en, word_en, valid_q;
  logic [WORD_W-1:0] base;

  always_comb begin
    base    = (slot_idx == 2'd0) ? '0 : acc_q;
    acc_d   = base | (WORD_W'(field) << (int'(slot_idx) * slot_w_of(mode)));
    acc_en  = take | flush;
    word_en = last | flush;
    word_d  = last ? acc_d : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (acc_en)
        acc_q <= flush ? '0 : acc_d;
      if (word_en)
        word_q <= word_d;
      valid_q <= word_en;
    end
  end

  assign word_valid = valid_q;
  assign word_data  = word_q;

  // R6: bits above the last slot are clear in an emitted word
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ((word_q >> used_bits_of(mode)) == '0));

endmodule

// File: rtl/trace_frame_packer.sv
module trace_frame_packer
  import tfp_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter logic [STAT_W-1:0] TRIG_CODE = 3'b110
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           port_mode,
  input  logic                 cap_en,
  input  logic                 smp_valid,
  input  logic [STAT_W-1:0]    smp_stat,
  input  logic [PKT_MAX_W-1:0] smp_pkt,
  input  logic                 smp_sync,
  input  logic                 smp_trig,
  output logic                 word_valid,
  output logic [WORD_W-1:0]    word_data,
  output logic                 drained
);

  logic                  take, last, flush;
  logic [1:0]            slot_idx;
  logic [SLOT_MAX_W-1:0] field;

  tfp_fmt #(.TRIG_CODE(TRIG_CODE)) i_fmt (
    .mode  (port_mode),
    .stat  (smp_stat),
    .pkt   (smp_pkt),
    .sync  (smp_sync),
    .trig  (smp_trig),
    .field (field)
  );

  tfp_slot_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (port_mode),
    .cap_en    (cap_en),
    .smp_valid (smp_valid),
    .take      (take),
    .slot_idx  (slot_idx),
    .last      (last),
    .flush     (flush),
    .drained   (drained)
  );

  tfp_word_asm #(.WORD_W(WORD_W)) i_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (port_mode),
    .take       (take),
    .slot_idx   (slot_idx),
    .last       (last),
    .flush      (flush),
    .field      (field),
    .word_valid (word_valid),
    .word_data  (word_data)
  );

  // R4: a word only appears after an accepted sample or a stop
  p_valid_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ($past(cap_en && smp_valid) || $past(!cap_en)));

  // R8: a word emitted after a stop is the last one, so drained rises with it
  p_flush_drains_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(!cap_en)) |-> drained);

  // R9: drained stays low while capture runs
  p_run_not_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_en) |-> !drained);

endmodule

// File: tb/test_trace_frame_packer.sv
module test_trace_frame_packer;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  port_mode;
  logic        cap_en, smp_valid, smp_sync, smp_trig;
  logic [2:0]  smp_stat;
  logic [15:0] smp_pkt;
  logic        word_valid, drained;
  logic [31:0] word_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // model state
  int          m_cnt = 0;
  logic [31:0] m_acc = '0;
  bit          m_trig_in = 0;
  bit          e_valid = 0;
  bit          e_drained = 1;
  logic [31:0] e_word = '0;
  string       e_tag = "";

  always #(CLK_P/2) clk = ~clk;

  trace_frame_packer i_trace_frame_packer (
    .clk(clk), .rst_n(rst_n), .port_mode(port_mode), .cap_en(cap_en),
    .smp_valid(smp_valid), .smp_stat(smp_stat), .smp_pkt(smp_pkt),
    .smp_sync(smp_sync), .smp_trig(smp_trig), .word_valid(word_valid),
    .word_data(word_data), .drained(drained)
  );

  function automatic int nslot(input int m);
    return (m == 0) ? 3 : (m == 1) ? 2 : 1;
  endfunction
  function automatic int pw(input int m);
    return (m == 0) ? 4 : (m == 1) ? 8 : 16;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, predict, compare at the next falling edge
  task automatic cyc(input bit cap, input bit v, input int st, input int pk,
                     input bit sy, input bit tr);
    int m, sw, p, stv;
    logic [31:0] f;
    bit ignored;
    cap_en = cap; smp_valid = v; smp_stat = 3'(st); smp_pkt = 16'(pk);
    smp_sync = sy; smp_trig = tr;
    m  = int'(port_mode);
    sw = pw(m) + 4;
    p  = pk & ((1 << pw(m)) - 1);
    stv = st;
    if (tr) begin
      p   = (p & ~7) | st;
      stv = 6;
    end
    f = 32'(stv) | (32'(p) << 3) | (32'(sy) << (pw(m) + 3));
    e_valid = 0;
    ignored = v && !cap;
    if (cap && v) begin
      if (m_cnt == 0) begin m_acc = '0; m_trig_in = 0; end
      m_acc = m_acc | (f << (m_cnt * sw));
      m_trig_in = m_trig_in | tr;
      if (m_cnt == nslot(m) - 1) begin
        e_valid = 1; e_word = m_acc; m_cnt = 0;
        e_tag = m_trig_in ? "R2 R3 R5 word" : "R2 R3 word";
      end else m_cnt++;
    end else if (!cap && m_cnt != 0) begin
      e_valid = 1; e_word = m_acc; m_cnt = 0; e_tag = "R8 flush word";
    end
    e_drained = !cap && (m_cnt == 0);
    @(posedge clk);
    #(CLK_P/2);
    chk(ignored ? "R7 ignored sample valid" : "R4 valid", 32'(word_valid), 32'(e_valid));
    chk("R9 drained", 32'(drained), 32'(e_drained));
    if (e_valid && word_valid) begin
      chk(e_tag, word_data, e_word);
      chk("R6 upper bits", word_data >> (nslot(m) * sw), 32'd0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; port_mode = 2'd0; cap_en = 0; smp_valid = 0;
    smp_stat = 0; smp_pkt = 0; smp_sync = 0; smp_trig = 0;
    #(CLK_P * 3 + CLK_P/2);
    chk("R1 reset valid", 32'(word_valid), 32'd0);
    chk("R1 reset drained", 32'(drained), 32'd1);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0, 0);
    chk("R1 idle drained", 32'(drained), 32'd1);

    for (int m = 0; m < 4; m++) begin
      port_mode = 2'(m);
      // R7: samples offered while capture is off are not taken
      for (int k = 0; k < 4; k++) cyc(0, 1, 7, 16'hFFFF, 1, k[0]);
      // partial fills of every length, closed by a stop
      for (int len = 1; len <= 5; len++) begin
        for (int i = 0; i < len; i++)
          cyc(1, 1, (i + len) % 8, (i * 4657 + len * 91 + m * 13) & 16'hFFFF,
              (i % 2) == 1, ((i + len) % 4) == 2);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
      end
      // long run with gaps and scattered triggers
      for (int i = 0; i < 40; i++)
        cyc(1, (i % 5) != 4, i % 8, (i * 40503 + m * 7) & 16'hFFFF,
            (i % 3) == 0, (i % 7) == 3);
      // R7 gap: capture on, no valid, then a stop in mid-word
      cyc(1, 0, 5, 16'h1234, 1, 1);
      cyc(0, 1, 5, 16'h1234, 1, 1);
      cyc(0, 0, 0, 0, 0, 0);
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule